// File: doc/BRIEF.md
# Dual-Mode Timer with Buffered High Byte

A byte-addressed timer/counter for a register bus. It counts either as one 16-bit value or as an 8-bit value that restarts at a programmed period. Counting ticks come from a selected source: an internal per-cycle count strobe, or rising edges of an external input that first passes through a synchroniser. Each tick then passes through a power-of-two prescaler. Every overflow or period match drives a pulse output and advances a postscaler, and the postscaler sets a sticky interrupt flag.

In 16-bit mode the high byte sits behind a holding register. A read of the low byte latches the live high byte into that register, and a write of the low byte loads the live high byte from it. Software therefore reads and writes the full count without tearing. In 8-bit mode the same holding register is the period value. It passes to the live period buffer only when a match occurs.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the low count reads 00h, address 1 reads FFh, both control registers read 00h, and the pulse output and flag are 0.
- R2: In 16-bit mode (control A bit 4 = 1) with run set (control A bit 7 = 1), every prescaled tick adds one to the 16-bit count. The carry from the low byte goes into the live high byte.
- R3: In 16-bit mode a read of address 0 copies the live high byte into the holding register in that same access, and address 1 returns the holding register.
- R4: In 16-bit mode a write to address 1 changes only the holding register. A write to address 0 loads the low byte from the bus and the live high byte from the holding register in one cycle.
- R5: In 8-bit mode the low byte is compared with the period buffer (reset value FFh) on each prescaled tick. On equality the low byte goes to 00h, the pulse output is 1 until the next prescaled tick, and the period buffer reloads from address 1. Otherwise the low byte increments. Writes to address 1 reach the period buffer only at the next match.
- R6: In 8-bit mode addresses 0 and 1 are plain read/write registers, and reads have no side effects.
- R7: Prescale code n (control B bits 3:0) advances the counter once per 2^n source ticks. Code 0 advances it on every source tick.
- R8: A write to address 0, 2 or 3 clears the prescaler and postscaler counts. No count tick occurs in that cycle.
- R9: Control B bits 7:5 pick the source: 000 = internal count strobe, 001 = rising edges of the external input after a two-flop synchroniser, any other code = no ticks.
- R10: Control A bits 3:0 = k sets the flag (control A bit 5) on every (k+1)th event. Writing control A with bit 5 = 0 clears the flag. Writing bit 5 = 1 leaves it unchanged.
- R11: With run clear, the count does not change.
- R12: In 16-bit mode the FFFFh to 0000h rollover is an event: it raises the pulse output and advances the postscaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 low count, 1 high/period, 2 control A, 3 control B |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| int_tick | input | 1 | Internal count strobe, one tick per cycle while high |
| ext_clk_in | input | 1 | External count input, asynchronous to clk |
| tmr_pulse | output | 1 | High for one prescaled tick after each match or rollover |
| irq_flag | output | 1 | Sticky interrupt flag after the postscaler |

## Verification
The bench first confirms that a read of the low byte latches the live high byte, then writes the holding register and confirms that the live high byte does not change. A design that wired address 1 straight to the counter would return the wrong byte at one of these two reads. It changes address 1 in the middle of an 8-bit period and checks that the old period still governs the next match; a single-buffered period would restart early. It steps through a 16-bit rollover and a postscaler ratio of 1:3, and checks that prescaler clears on low-byte and control writes lose a partial prescale count, which a design with missing clears would count one tick early. Held high levels on the external input, the internal strobe while the external source is selected, and unmodelled source codes must all leave the count unchanged.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int PRE_SEL_W  = 4;
    localparam int PRE_CNT_W  = 15;
    localparam int POST_SEL_W = 4;
    localparam int SRC_SEL_W  = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL_A = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL_B = 2'd3;

    localparam logic [SRC_SEL_W-1:0] SRC_INTERNAL = 3'd0;
    localparam logic [SRC_SEL_W-1:0] SRC_EXTERNAL = 3'd1;

    localparam int CA_RUN  = 7;
    localparam int CA_FLAG = 5;
    localparam int CA_WIDE = 4;
    localparam int CB_SRC_LSB = 5;

    typedef struct packed {
        logic [BYTE_W-1:0]     lo;
        logic [BYTE_W-1:0]     hi_live;
        logic [BYTE_W-1:0]     hi_reg;
        logic [BYTE_W-1:0]     period;
        logic                  run;
        logic                  wide;
        logic                  flag;
        logic                  pulse;
        logic [POST_SEL_W-1:0] post_sel;
        logic [SRC_SEL_W-1:0]  src_sel;
        logic [PRE_SEL_W-1:0]  pre_sel;
    } tmr_regs_t;
endpackage

// File: rtl/dmt_tick_src.sv
module dmt_tick_src
    import dmt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [SRC_SEL_W-1:0] src_sel,
    input  logic                 int_tick,
    input  logic                 ext_in,
    output logic                 tick_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } sync_state_t;

    sync_state_t s_d, s_q;
    logic        ext_rise;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], ext_in};
        s_d.last = s_q.sync[SYNC_STAGES-1];
        ext_rise = s_q.sync[SYNC_STAGES-1] & ~s_q.last;
        tick_o   = 1'b0;
        if (run) begin
            if (src_sel == SRC_INTERNAL)      tick_o = int_tick;
            else if (src_sel == SRC_EXTERNAL) tick_o = ext_rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: a held external level yields only one tick per rising edge
    assert_single_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
    parameter int SEL_W = 4,
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    logic [31:0]      shift;

    always_comb begin
        shift  = (32'(sel) > 32'(CNT_W)) ? 32'(CNT_W) : 32'(sel);
        limit  = CNT_W'((33'd1 << shift) - 33'd1);
        tick_o = tick_i & ~clr & (cnt_q == limit);
        cnt_d  = cnt_q;
        if (clr)                 cnt_d = '0;
        else if (tick_i) begin
            if (cnt_q == limit)  cnt_d = '0;
            else                 cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    assert_div_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/dmt_postscaler.sv
module dmt_postscaler #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic [SEL_W-1:0] sel,
    output logic             fire_o
);
    logic [SEL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire_o = evt & ~clr & (cnt_q == sel);
        cnt_d  = cnt_q;
        if (clr)             cnt_d = '0;
        else if (evt) begin
            if (cnt_q == sel) cnt_d = '0;
            else              cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_post_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= sel);
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import dmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              int_tick,
    input  logic              ext_clk_in,
    output logic              tmr_pulse,
    output logic              irq_flag
);
    localparam int WIDE_W = 2 * BYTE_W;

    tmr_regs_t         r_d, r_q;
    logic              src_tick, pre_tick, evt, post_fire, scal_clr;
    logic [WIDE_W-1:0] wide_cnt, wide_nxt;

    dmt_tick_src #(.SYNC_STAGES(2)) u_src (
        .clk(clk), .rst_n(rst_n), .run(r_q.run), .src_sel(r_q.src_sel),
        .int_tick(int_tick), .ext_in(ext_clk_in), .tick_o(src_tick)
    );

    dmt_prescaler #(.SEL_W(PRE_SEL_W), .CNT_W(PRE_CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(scal_clr), .tick_i(src_tick),
        .sel(r_q.pre_sel), .tick_o(pre_tick)
    );

    dmt_postscaler #(.SEL_W(POST_SEL_W)) u_post (
        .clk(clk), .rst_n(rst_n), .clr(scal_clr), .evt(evt),
        .sel(r_q.post_sel), .fire_o(post_fire)
    );

    always_comb begin
        scal_clr = bus_wr & (bus_addr != A_CNT_HI);
        wide_cnt = {r_q.hi_live, r_q.lo};
        wide_nxt = wide_cnt + 1'b1;
        evt      = 1'b0;
        r_d      = r_q;

        // counting path
        if (pre_tick) begin
            if (r_q.wide) begin
                {r_d.hi_live, r_d.lo} = wide_nxt;
                evt = (wide_cnt == '1);
            end else if (r_q.lo == r_q.period) begin
                r_d.lo     = '0;
                r_d.period = r_q.hi_reg;
                evt        = 1'b1;
            end else begin
                r_d.lo = r_q.lo + 1'b1;
            end
            r_d.pulse = evt;
        end

        if (post_fire) r_d.flag = 1'b1;

        // atomic high-byte capture on a low-byte read
        if (bus_rd && !bus_wr && bus_addr == A_CNT_LO && r_q.wide)
            r_d.hi_reg = r_q.hi_live;

        // register writes win over counting
        if (bus_wr) begin
            unique case (bus_addr)
                A_CNT_LO: begin
                    r_d.lo = bus_wdata;
                    if (r_q.wide) r_d.hi_live = r_q.hi_reg;
                end
                A_CNT_HI: r_d.hi_reg = bus_wdata;
                A_CTRL_A: begin
                    r_d.run      = bus_wdata[CA_RUN];
                    r_d.wide     = bus_wdata[CA_WIDE];
                    r_d.flag     = r_q.flag & bus_wdata[CA_FLAG];
                    r_d.post_sel = bus_wdata[POST_SEL_W-1:0];
                end
                default: begin
                    r_d.src_sel = bus_wdata[CB_SRC_LSB +: SRC_SEL_W];
                    r_d.pre_sel = bus_wdata[PRE_SEL_W-1:0];
                end
            endcase
        end

        unique case (bus_addr)
            A_CNT_LO: bus_rdata = r_q.lo;
            A_CNT_HI: bus_rdata = r_q.hi_reg;
            A_CTRL_A: bus_rdata = {r_q.run, 1'b0, r_q.flag, r_q.wide, r_q.post_sel};
            default:  bus_rdata = {r_q.src_sel, 1'b0, r_q.pre_sel};
        endcase

        tmr_pulse = r_q.pulse;
        irq_flag  = r_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.hi_reg <= '1;
            r_q.period <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assert_inc16_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.wide && pre_tick && !bus_wr && {r_q.hi_live, r_q.lo} != '1)
        |=> {r_q.hi_live, r_q.lo} == $past({r_q.hi_live, r_q.lo}) + 16'd1);

    assert_match_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.wide && pre_tick && r_q.lo == r_q.period && !bus_wr)
        |=> (r_q.lo == '0 && r_q.period == $past(r_q.hi_reg) && tmr_pulse));

    assert_hi_buffer_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.wide && bus_wr && bus_addr == A_CNT_HI && !pre_tick)
        |=> r_q.hi_live == $past(r_q.hi_live));

    assert_flag_from_post_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(post_fire));

    assert_pulse_from_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_pulse) |-> $past(evt));

    assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.run && !bus_wr) |=> r_q.lo == $past(r_q.lo));
endmodule

// File: tb/test_dual_mode_timer.sv
`timescale 1ns/1ps
module test_dual_mode_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       int_tick = 1'b0, ext_clk_in = 1'b0;
    logic       tmr_pulse, irq_flag;
    int         n_checks = 0, n_fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    dual_mode_timer i_dual_mode_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_tick(int_tick), .ext_clk_in(ext_clk_in),
        .tmr_pulse(tmr_pulse), .irq_flag(irq_flag)
    );

    // vector: [23:20] req, [19:18] op (0 write, 1 read+check), [17:16] addr, [15:8] data, [7:0] expected
    localparam int NV = 26;
    localparam logic [23:0] VEC [NV] = '{
        {4'd1,  2'd1, 2'd0, 8'h00, 8'h00},  // R1
        {4'd1,  2'd1, 2'd1, 8'h00, 8'hFF},  // R1
        {4'd1,  2'd1, 2'd2, 8'h00, 8'h00},  // R1
        {4'd1,  2'd1, 2'd3, 8'h00, 8'h00},  // R1
        {4'd6,  2'd0, 2'd1, 8'h5A, 8'h00},  // R6
        {4'd6,  2'd1, 2'd1, 8'h00, 8'h5A},
        {4'd6,  2'd1, 2'd0, 8'h00, 8'h00},
        {4'd6,  2'd1, 2'd1, 8'h00, 8'h5A},
        {4'd6,  2'd0, 2'd0, 8'h33, 8'h00},
        {4'd6,  2'd1, 2'd0, 8'h00, 8'h33},
        {4'd4,  2'd0, 2'd2, 8'h10, 8'h00},  // R4 enter 16-bit
        {4'd4,  2'd1, 2'd2, 8'h00, 8'h10},
        {4'd4,  2'd0, 2'd1, 8'hC4, 8'h00},
        {4'd4,  2'd1, 2'd1, 8'h00, 8'hC4},
        {4'd3,  2'd1, 2'd0, 8'h00, 8'h33},  // R3 latches live high (00)
        {4'd3,  2'd1, 2'd1, 8'h00, 8'h00},
        {4'd4,  2'd0, 2'd1, 8'hC4, 8'h00},
        {4'd4,  2'd0, 2'd0, 8'h77, 8'h00},
        {4'd4,  2'd1, 2'd0, 8'h00, 8'h77},
        {4'd3,  2'd1, 2'd1, 8'h00, 8'hC4},
        {4'd10, 2'd0, 2'd2, 8'h30, 8'h00},  // R10 writing 1 does not set
        {4'd10, 2'd1, 2'd2, 8'h00, 8'h10},
        {4'd9,  2'd0, 2'd3, 8'h2F, 8'h00},  // R9
        {4'd9,  2'd1, 2'd3, 8'h00, 8'h2F},
        {4'd9,  2'd0, 2'd3, 8'h00, 8'h00},
        {4'd9,  2'd1, 2'd3, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        int_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 int_tick = 1'b0;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk_in = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 pulse", {7'd0, tmr_pulse}, 8'h00);
        check("R1 flag", {7'd0, irq_flag}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[k][23:20], k);
            if (VEC[k][19:18] == 2'd0) wr(VEC[k][17:16], VEC[k][15:8]);
            else begin
                rd(VEC[k][17:16], v);
                check(tag, v, VEC[k][7:0]);
            end
        end

        // R2: carry into the high byte
        wr(2'd1, 8'h00); wr(2'd0, 8'hFE); wr(2'd2, 8'h90);
        ticks(3);
        rd_chk("R2 lo", 2'd0, 8'h01);
        rd_chk("R2 hi", 2'd1, 8'h01);

        // R12: 16-bit rollover is an event
        wr(2'd1, 8'hFF); wr(2'd0, 8'hFE);
        ticks(1);
        check("R12 pulse before", {7'd0, tmr_pulse}, 8'h00);
        ticks(1);
        check("R12 pulse", {7'd0, tmr_pulse}, 8'h01);
        check("R12 flag", {7'd0, irq_flag}, 8'h01);
        rd_chk("R12 ctrl", 2'd2, 8'hB0);
        rd_chk("R12 lo", 2'd0, 8'h00);
        ticks(1);
        check("R12 pulse after", {7'd0, tmr_pulse}, 8'h00);
        rd_chk("R12 lo next", 2'd0, 8'h01);

        // R10: clear by writing 0
        wr(2'd2, 8'h90);
        rd_chk("R10 clear", 2'd2, 8'h90);

        // R5: 8-bit period match
        wr(2'd2, 8'h80); wr(2'd1, 8'h03); wr(2'd0, 8'hFF);
        ticks(1);
        check("R5 pulse first", {7'd0, tmr_pulse}, 8'h01);
        rd_chk("R5 lo reset", 2'd0, 8'h00);
        ticks(3);
        rd_chk("R5 lo 3", 2'd0, 8'h03);
        check("R5 pulse low", {7'd0, tmr_pulse}, 8'h00);
        ticks(1);
        check("R5 pulse match", {7'd0, tmr_pulse}, 8'h01);
        rd_chk("R5 lo wrap", 2'd0, 8'h00);
        rd_chk("R6 hi direct", 2'd1, 8'h03);

        // R10: postscale 1:3
        wr(2'd2, 8'h82); wr(2'd0, 8'h00);
        ticks(8);
        rd_chk("R10 two events", 2'd2, 8'h82);
        ticks(4);
        rd_chk("R10 third event", 2'd2, 8'hA2);

        // R5: new period waits for the next match
        wr(2'd1, 8'h05);
        ticks(3);
        rd_chk("R5 old period", 2'd0, 8'h03);
        ticks(1);
        rd_chk("R5 old match", 2'd0, 8'h00);
        ticks(5);
        rd_chk("R5 new period", 2'd0, 8'h05);
        ticks(1);
        rd_chk("R5 new match", 2'd0, 8'h00);

        // R7: divide by 4
        wr(2'd3, 8'h02); wr(2'd0, 8'h00);
        ticks(7);
        rd_chk("R7 seven", 2'd0, 8'h01);
        ticks(1);
        rd_chk("R7 eight", 2'd0, 8'h02);

        // R8: clears on low-byte and control writes
        ticks(3);
        wr(2'd0, 8'h10);
        ticks(3);
        rd_chk("R8 lo write", 2'd0, 8'h10);
        ticks(1);
        rd_chk("R8 lo write next", 2'd0, 8'h11);
        ticks(3);
        wr(2'd3, 8'h02);
        ticks(3);
        rd_chk("R8 ctrl write", 2'd0, 8'h11);
        ticks(1);
        rd_chk("R8 ctrl write next", 2'd0, 8'h12);

        // R11: stopped
        wr(2'd3, 8'h00); wr(2'd2, 8'h00);
        ticks(10);
        rd_chk("R11 halted", 2'd0, 8'h12);

        // R9: external edges only, internal strobe ignored
        wr(2'd3, 8'h20); wr(2'd2, 8'h90); wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        @(negedge clk); int_tick = 1'b1;
        ext_pulses(5);
        int_tick = 1'b0;
        rd_chk("R9 ext count", 2'd0, 8'h05);
        rd_chk("R9 ext hi", 2'd1, 8'h00);
        wr(2'd3, 8'h40);
        @(negedge clk); int_tick = 1'b1;
        ext_pulses(3);
        int_tick = 1'b0;
        rd_chk("R9 disabled source", 2'd0, 8'h05);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule